// File: doc/BRIEF.md
# Atomic Swap Memory Responder

A word-organised memory target that answers read, write, swap and compare-and-swap requests, along with two data-less housekeeping commands. A request is presented for one cycle with a command code, a byte address, a transfer size of 4 or 8 bytes, write data, a compare value, a source number and flags. The reply, or an error pulse, follows in the next cycle. Swaps finish in that same single cycle: the old contents go back to the requester and the new value is stored, unless a compare-and-swap finds that the stored value differs from the compare operand.

Some requests are deliberately absorbed. If another agent already owns the reply (the cache-responding flag), the memory does nothing at all. Clean-eviction traffic is swallowed silently. For each source the block also keeps traffic counters, which can be read combinationally through a side port.

Storage is a DEPTH x 64-bit register array that starts at byte address BASE, which must be 8-byte aligned. Command codes: 0 read, 1 write, 2 swap, 3 compare-and-swap, 4 clean eviction, 5 maintenance. Codes 6 and 7 are illegal.

Top module: `atomic_mem_responder`

## Requirements
- R1: A read of size 8 returns the whole 64-bit word at (addr-BASE)>>3. A read of size 4 returns, in bits 31:0 with the upper bits zero, the half selected by address bit 2 (1 = upper half). The reply and its rsp_src appear in the cycle after the request.
- R2: A write of size 8 stores req_wdata. A write of size 4 stores req_wdata[31:0] into the half selected by address bit 2 and leaves the other half unchanged. A write reply, when one is requested, carries zero data.
- R3: A swap (code 2) returns the old contents, shaped as in R1, and always stores the write data, shaped as in R2.
- R4: A compare-and-swap (code 3) returns the old contents. It stores the write data only if the old contents equal req_cmp exactly: all 64 bits for size 8, bits 31:0 for size 4.
- R5: While req_cache_resp is set, a request makes no memory access, gives no reply, raises no error and changes no counter.
- R6: Clean eviction (code 4) makes no access and gives no reply. Maintenance (code 5) makes no access and replies with zero data if req_need_resp is set. Neither command changes any counter.
- R7: rsp_valid rises only for a request that had req_need_resp set. A request that raises an error never gets a reply.
- R8: err_o pulses in the cycle after any of the following, and the request then makes no access and changes no counter: a data command whose size is neither 4 nor 8, an address outside [BASE, BASE+DEPTH*8), an address misaligned for its size, or command 6 or 7.
- R9: Per source, stat_sel selects one counter: 0 reads, 1 writes, 2 swap-class operations, 3 read bytes, 4 written bytes. Any other select reads zero.
- R10: A read with req_ifetch set also adds its size to the instruction-byte counter, select 5.
- R11: Counters saturate at 2^CNT_W-1 and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_cmd | input | 3 | Command code |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Transfer size in bytes |
| req_wdata | input | DATA_W | Write / swap data |
| req_cmp | input | DATA_W | Compare operand for compare-and-swap |
| req_src | input | SRC_W | Source number |
| req_need_resp | input | 1 | Requester expects a reply |
| req_ifetch | input | 1 | Read is an instruction fetch |
| req_cache_resp | input | 1 | Another agent is answering this request |
| rsp_valid | output | 1 | Reply present |
| rsp_data | output | DATA_W | Read or old data |
| rsp_src | output | SRC_W | Source of the reply |
| err_o | output | 1 | Request error pulse |
| stat_src | input | SRC_W | Source whose counter is read |
| stat_sel | input | 3 | Counter select |
| stat_value | output | CNT_W | Selected counter value |

## Verification
On every cycle the assertions check the following: no reply comes without a requested reply, a reply and an error never occur together, absorbed and cache-answered requests give neither, saturating counters never decrease, a failed compare-and-swap leaves its word intact, and an unconditional full-width swap stores its data. The data values themselves, the half-word placement, the choice of counter each command updates, and the saturation point are shown only by the bench's sweeps, which compare against a reference memory and counter set computed inside the bench.

// File: rtl/amr_pkg.sv
package amr_pkg;

   typedef enum logic [2:0] {
      CMD_READ  = 3'd0,
      CMD_WRITE = 3'd1,
      CMD_SWAP  = 3'd2,
      CMD_CAS   = 3'd3,
      CMD_EVICT = 3'd4,
      CMD_MAINT = 3'd5
   } amr_cmd_e;

   typedef enum logic [2:0] {
      SEL_RD_CNT   = 3'd0,
      SEL_WR_CNT   = 3'd1,
      SEL_OTH_CNT  = 3'd2,
      SEL_RD_BYTES = 3'd3,
      SEL_WR_BYTES = 3'd4,
      SEL_IF_BYTES = 3'd5
   } amr_stat_e;

   localparam int NUM_STATS = 6;

   // decoded action for one request
   typedef struct packed {
      logic rd;
      logic wr;
      logic swap;
      logic cond;
      logic wide;
      logic reply;
      logic err;
   } amr_act_t;

endpackage

// File: rtl/amr_decode.sv
module amr_decode
   import amr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DEPTH  = 256,
   parameter logic [ADDR_W-1:0] BASE = '0,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              valid,
   input  logic [2:0]        cmd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [3:0]        size,
   input  logic              need_resp,
   input  logic              cache_resp,
   output amr_act_t          act,
   output logic [IDX_W-1:0]  idx,
   output logic              half
);

   localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(DEPTH * 8);

   logic [ADDR_W:0] off;
   logic            in_rng;
   logic            size_ok;
   logic            aligned;
   logic            wide;

   assign off     = {1'b0, addr} - {1'b0, BASE};
   assign in_rng  = off < SPAN;
   assign wide    = size == 4'd8;
   assign size_ok = wide || size == 4'd4;
   assign aligned = wide ? (addr[2:0] == 3'd0) : (addr[1:0] == 2'd0);
   assign idx     = off[IDX_W+2:3];
   assign half    = off[2];

   always_comb begin
      act      = '0;
      act.wide = wide;
      if (valid && !cache_resp) begin
         case (amr_cmd_e'(cmd))
            CMD_READ, CMD_WRITE, CMD_SWAP, CMD_CAS: begin
               if (!(size_ok && aligned && in_rng)) begin
                  act.err = 1'b1;
               end else begin
                  act.rd    = cmd == CMD_READ;
                  act.wr    = cmd == CMD_WRITE;
                  act.swap  = cmd == CMD_SWAP || cmd == CMD_CAS;
                  act.cond  = cmd == CMD_CAS;
                  act.reply = need_resp;
               end
            end
            CMD_EVICT: act.reply = 1'b0;
            CMD_MAINT: act.reply = need_resp;
            default:   act.err   = 1'b1;
         endcase
      end
   end

endmodule

// File: rtl/amr_store.sv
module amr_store
   import amr_pkg::*;
#(
   parameter int DEPTH  = 256,
   parameter int DATA_W = 64,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int HALF_W = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  amr_act_t          act,
   input  logic [IDX_W-1:0]  idx,
   input  logic              half,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] cmp,
   output logic [DATA_W-1:0] old_data
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] word;
   logic [HALF_W-1:0] part;
   logic [DATA_W-1:0] new_word;
   logic              match;
   logic              wr_en;

   assign word     = mem[idx];
   assign part     = half ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];
   assign old_data = act.wide ? word : {{HALF_W{1'b0}}, part};
   assign match    = act.wide ? (word == cmp) : (part == cmp[HALF_W-1:0]);
   assign wr_en    = act.wr || (act.swap && (!act.cond || match));

   always_comb begin
      if (act.wide)
         new_word = wdata;
      else if (half)
         new_word = {wdata[HALF_W-1:0], word[HALF_W-1:0]};
      else
         new_word = {word[DATA_W-1:HALF_W], wdata[HALF_W-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[idx] <= new_word;
      end
   end

   // R4
   cas_miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act.swap && act.cond && !match) |=> (mem[$past(idx)] == $past(word)));

   // R3
   swap_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act.swap && !act.cond && act.wide) |=> (mem[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/amr_stats.sv
module amr_stats
   import amr_pkg::*;
#(
   parameter int SRC_N    = 4,
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1,
   localparam int SRC_W   = $clog2(SRC_N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  amr_act_t         act,
   input  logic [SRC_W-1:0] src,
   input  logic             ifetch,
   input  logic [3:0]       size,
   input  logic [SRC_W-1:0] stat_src,
   input  logic [2:0]       stat_sel,
   output logic [CNT_W-1:0] stat_value
);

   logic [CNT_W-1:0] amt [NUM_STATS];
   logic [CNT_W-1:0] cnt [SRC_N][NUM_STATS];
   logic [CNT_W-1:0] bytes;

   assign bytes = CNT_W'(size);

   always_comb begin
      amt[SEL_RD_CNT]   = act.rd   ? CNT_W'(1) : '0;
      amt[SEL_WR_CNT]   = act.wr   ? CNT_W'(1) : '0;
      amt[SEL_OTH_CNT]  = act.swap ? CNT_W'(1) : '0;
      amt[SEL_RD_BYTES] = act.rd   ? bytes     : '0;
      amt[SEL_WR_BYTES] = act.wr   ? bytes     : '0;
      amt[SEL_IF_BYTES] = (act.rd && ifetch) ? bytes : '0;
   end

   for (genvar s = 0; s < SRC_N; s++) begin : g_src
      for (genvar k = 0; k < NUM_STATS; k++) begin : g_cnt
         logic [CNT_W:0]   sum;
         logic [CNT_W-1:0] nxt;
         logic             hit;
         assign hit = src == SRC_W'(s);
         assign sum = {1'b0, cnt[s][k]} + {1'b0, amt[k]};
         if (SATURATE) begin : g_sat
            assign nxt = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
            // R11
            cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
               1'b1 |=> (cnt[s][k] >= $past(cnt[s][k])));
         end else begin : g_wrap
            assign nxt = sum[CNT_W-1:0];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt[s][k] <= '0;
            else if (hit) cnt[s][k] <= nxt;
         end
      end
   end

   always_comb begin
      if (int'(stat_sel) < NUM_STATS) stat_value = cnt[stat_src][stat_sel];
      else                            stat_value = '0;
   end

endmodule

// File: rtl/atomic_mem_responder.sv
module atomic_mem_responder
   import amr_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DEPTH    = 256,
   parameter int DATA_W   = 64,
   parameter int SRC_N    = 4,
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1,
   parameter logic [ADDR_W-1:0] BASE = '0,
   localparam int SRC_W   = $clog2(SRC_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_cmd,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [3:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] req_cmp,
   input  logic [SRC_W-1:0]  req_src,
   input  logic              req_need_resp,
   input  logic              req_ifetch,
   input  logic              req_cache_resp,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [SRC_W-1:0]  rsp_src,
   output logic              err_o,
   input  logic [SRC_W-1:0]  stat_src,
   input  logic [2:0]        stat_sel,
   output logic [CNT_W-1:0]  stat_value
);

   localparam int IDX_W = $clog2(DEPTH);

   initial begin
      assert (DATA_W == 64) else $error("DATA_W must be 64");
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0) else $error("DEPTH must be a power of two");
      assert (SRC_N >= 2 && (SRC_N & (SRC_N - 1)) == 0) else $error("SRC_N must be a power of two");
      assert (ADDR_W >= IDX_W + 4) else $error("ADDR_W too narrow for DEPTH");
      assert (BASE[2:0] == 3'd0) else $error("BASE must be 8-byte aligned");
      assert (CNT_W >= 8) else $error("CNT_W must hold a byte count");
   end

   amr_act_t          act;
   logic [IDX_W-1:0]  idx;
   logic              half;
   logic [DATA_W-1:0] old_data;

   amr_decode #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BASE(BASE)) u_decode (
      .valid(req_valid), .cmd(req_cmd), .addr(req_addr), .size(req_size),
      .need_resp(req_need_resp), .cache_resp(req_cache_resp),
      .act(act), .idx(idx), .half(half)
   );

   amr_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
      .clk(clk), .rst_n(rst_n), .act(act), .idx(idx), .half(half),
      .wdata(req_wdata), .cmp(req_cmp), .old_data(old_data)
   );

   amr_stats #(.SRC_N(SRC_N), .CNT_W(CNT_W), .SATURATE(SATURATE)) u_stats (
      .clk(clk), .rst_n(rst_n), .act(act), .src(req_src), .ifetch(req_ifetch),
      .size(req_size), .stat_src(stat_src), .stat_sel(stat_sel),
      .stat_value(stat_value)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
         rsp_src   <= '0;
         err_o     <= 1'b0;
      end else begin
         rsp_valid <= act.reply;
         rsp_data  <= (act.rd || act.swap) ? old_data : '0;
         rsp_src   <= req_src;
         err_o     <= act.err;
      end
   end

   // R7
   reply_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && req_need_resp));

   // R7
   reply_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && err_o));

   // R5
   cache_absorb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cache_resp) |=> (!rsp_valid && !err_o));

   // R6
   evict_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_cmd == 3'd4) |=> (!rsp_valid && !err_o));

endmodule

// File: tb/atomic_mem_responder_test.sv
module atomic_mem_responder_test;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int CNT_W = 8;
   localparam logic [15:0] BASE = 16'h0100;
   localparam int SAT_MAX = 255;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_cmd = '0;
   logic [15:0] req_addr = '0;
   logic [3:0]  req_size = '0;
   logic [63:0] req_wdata = '0;
   logic [63:0] req_cmp = '0;
   logic [1:0]  req_src = '0;
   logic        req_need_resp = 1'b0;
   logic        req_ifetch = 1'b0;
   logic        req_cache_resp = 1'b0;
   logic        rsp_valid;
   logic [63:0] rsp_data;
   logic [1:0]  rsp_src;
   logic        err_o;
   logic [1:0]  stat_src = '0;
   logic [2:0]  stat_sel = '0;
   logic [CNT_W-1:0] stat_value;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [63:0] mdl [DEPTH];
   int st [4][6];

   always #(CLK_PERIOD/2) clk = ~clk;

   atomic_mem_responder #(.ADDR_W(16), .DEPTH(DEPTH), .DATA_W(64), .SRC_N(4),
                          .CNT_W(CNT_W), .SATURATE(1'b1), .BASE(BASE)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .req_cmp(req_cmp), .req_src(req_src), .req_need_resp(req_need_resp),
      .req_ifetch(req_ifetch), .req_cache_resp(req_cache_resp),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_src(rsp_src),
      .err_o(err_o), .stat_src(stat_src), .stat_sel(stat_sel),
      .stat_value(stat_value)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic void bump(input int s, input int k, input int amt);
      st[s][k] = (st[s][k] + amt > SAT_MAX) ? SAT_MAX : st[s][k] + amt;
   endfunction

   function automatic void put(input int w, input bit hi, input logic [3:0] sz, input logic [63:0] wd);
      if (sz == 4'd8)  mdl[w] = wd;
      else if (hi)     mdl[w] = {wd[31:0], mdl[w][31:0]};
      else             mdl[w] = {mdl[w][63:32], wd[31:0]};
   endfunction

   task automatic op(input logic [2:0] c, input logic [15:0] a, input logic [3:0] sz,
                     input logic [63:0] wd, input logic [63:0] cp, input logic [1:0] s,
                     input logic nr, input logic fi, input logic cr, input string tag);
      bit e_rsp = 1'b0;
      bit e_err = 1'b0;
      bit acc = 1'b0;
      logic [63:0] e_dat = '0;
      logic [63:0] cur, oldv;
      int w;
      bit hi;
      if (!cr && c != 3'd4) begin
         if (c == 3'd5) e_rsp = nr;
         else if (c > 3'd5) e_err = 1'b1;
         else if ((sz == 4'd4 || sz == 4'd8) && a >= BASE && a < BASE + 16'(DEPTH*8) &&
                  (sz == 4'd8 ? a[2:0] == 3'd0 : a[1:0] == 2'd0)) begin
            acc = 1'b1; e_rsp = nr;
         end else e_err = 1'b1;
      end
      if (acc) begin
         w = int'(a - BASE) >> 3;
         hi = a[2];
         cur = mdl[w];
         oldv = (sz == 4'd8) ? cur : (hi ? {32'h0, cur[63:32]} : {32'h0, cur[31:0]});
         case (c)
            3'd0: begin e_dat = oldv; bump(s, 0, 1); bump(s, 3, sz); if (fi) bump(s, 5, sz); end
            3'd1: begin put(w, hi, sz, wd); bump(s, 1, 1); bump(s, 4, sz); end
            default: begin
               e_dat = oldv;
               if (c == 3'd2 || (sz == 4'd8 ? cur == cp : oldv[31:0] == cp[31:0])) put(w, hi, sz, wd);
               bump(s, 2, 1);
            end
         endcase
      end
      @(negedge clk);
      req_valid = 1'b1; req_cmd = c; req_addr = a; req_size = sz; req_wdata = wd;
      req_cmp = cp; req_src = s; req_need_resp = nr; req_ifetch = fi; req_cache_resp = cr;
      @(negedge clk);
      req_valid = 1'b0; req_cache_resp = 1'b0;
      chk(rsp_valid === e_rsp, {tag, " rsp_valid"}, 64'(rsp_valid), 64'(e_rsp));
      chk(err_o === e_err, {tag, " err"}, 64'(err_o), 64'(e_err));
      if (e_rsp) begin
         chk(rsp_data === e_dat, {tag, " data"}, rsp_data, e_dat);
         chk(rsp_src === s, {tag, " src"}, 64'(rsp_src), 64'(s));
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
      for (int s = 0; s < 4; s++) for (int k = 0; k < 6; k++) st[s][k] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(rsp_valid === 1'b0, "R7 reset rsp_valid", 64'(rsp_valid), 0);
      chk(err_o === 1'b0, "R8 reset err", 64'(err_o), 0);
      chk(stat_value === '0, "R9 reset counter", 64'(stat_value), 0);

      // R2 / R1: full-width sweep
      for (int i = 0; i < DEPTH; i++)
         op(3'd1, BASE + 16'(i*8), 4'd8, 64'h0123_4567_89AB_CDEF * 64'(i+3) ^ 64'(i), '0, 2'(i), 1'(i%2), 0, 0, "R2 wide write");
      for (int i = 0; i < DEPTH; i++)
         op(3'd0, BASE + 16'(i*8), 4'd8, '0, '0, 2'(i+1), 1, 0, 0, "R1 wide read");
      // R2 / R1: half-width writes and reads of both halves
      for (int i = 0; i < 4; i++) begin
         op(3'd1, BASE + 16'(i*8), 4'd4, 64'hFFFF_0000_A5A5_0000 + 64'(i), '0, 2'(i), 1, 0, 0, "R2 low half write");
         op(3'd1, BASE + 16'(i*8+4), 4'd4, 64'hEEEE_1111_5A5A_0000 + 64'(i), '0, 2'(i), 1, 0, 0, "R2 high half write");
      end
      for (int i = 0; i < DEPTH; i++) begin
         op(3'd0, BASE + 16'(i*8), 4'd4, '0, '0, 2'(i), 1, 0, 0, "R1 low half read");
         op(3'd0, BASE + 16'(i*8+4), 4'd4, '0, '0, 2'(i), 1, 0, 0, "R1 high half read");
      end
      // R3 swaps
      for (int i = 4; i < 8; i++) begin
         op(3'd2, BASE + 16'(i*8), 4'd8, 64'hC0DE_0000_0000_0000 | 64'(i), '0, 2'(i), 1, 0, 0, "R3 wide swap");
         op(3'd2, BASE + 16'(i*8+4), 4'd4, 64'h0000_0000_BEEF_0000 | 64'(i), '0, 2'(i), 1, 0, 0, "R3 half swap");
         op(3'd0, BASE + 16'(i*8), 4'd8, '0, '0, 2'(i), 1, 0, 0, "R3 swap readback");
      end
      // R4 compare-and-swap, hit and miss, both sizes
      for (int i = 8; i < 12; i++) begin
         op(3'd3, BASE + 16'(i*8), 4'd8, 64'h1111_2222_3333_4444, mdl[i] ^ 64'h1, 2'(i), 1, 0, 0, "R4 wide miss");
         op(3'd3, BASE + 16'(i*8), 4'd8, 64'h1111_2222_3333_4444 + 64'(i), mdl[i], 2'(i), 1, 0, 0, "R4 wide hit");
         op(3'd3, BASE + 16'(i*8+4), 4'd4, 64'h9999_0000, {32'hFFFF_FFFF, mdl[i][63:32]}, 2'(i), 1, 0, 0, "R4 half hit");
         op(3'd3, BASE + 16'(i*8), 4'd4, 64'h7777_0000, {32'h0, ~mdl[i][31:0]}, 2'(i), 1, 0, 0, "R4 half miss");
         op(3'd0, BASE + 16'(i*8), 4'd8, '0, '0, 2'(i), 1, 0, 0, "R4 readback");
      end
      // R8 error cases
      op(3'd3, BASE, 4'd2, '1, '0, 2'd1, 1, 0, 0, "R8 cas size 2");
      op(3'd0, BASE, 4'd1, '0, '0, 2'd1, 1, 0, 0, "R8 read size 1");
      op(3'd1, BASE - 16'd8, 4'd8, '1, '0, 2'd1, 1, 0, 0, "R8 below range");
      op(3'd1, BASE + 16'(DEPTH*8), 4'd8, '1, '0, 2'd1, 1, 0, 0, "R8 above range");
      op(3'd1, BASE + 16'(DEPTH*8-4), 4'd4, 64'h4242_4242, '0, 2'd1, 1, 0, 0, "R8 last half in range");
      op(3'd1, BASE + 16'd2, 4'd4, '1, '0, 2'd1, 1, 0, 0, "R8 misaligned half");
      op(3'd2, BASE + 16'd4, 4'd8, '1, '0, 2'd1, 1, 0, 0, "R8 misaligned wide");
      op(3'd6, BASE, 4'd8, '1, '0, 2'd1, 1, 0, 0, "R8 cmd 6");
      op(3'd7, BASE, 4'd8, '1, '0, 2'd1, 1, 0, 0, "R8 cmd 7");
      // R5 cache responding
      op(3'd1, BASE + 16'd8, 4'd8, 64'hDEAD, '0, 2'd2, 1, 0, 1, "R5 cache write");
      op(3'd2, BASE + 16'd16, 4'd8, 64'hDEAD, '0, 2'd2, 1, 0, 1, "R5 cache swap");
      op(3'd0, BASE + 16'd8, 4'd8, '0, '0, 2'd2, 1, 0, 0, "R5 unchanged");
      op(3'd0, BASE + 16'd16, 4'd8, '0, '0, 2'd2, 1, 0, 0, "R5 unchanged");
      // R6 eviction and maintenance
      op(3'd4, BASE + 16'd24, 4'd8, 64'hDEAD, '0, 2'd0, 1, 0, 0, "R6 evict");
      op(3'd5, BASE + 16'd24, 4'd8, 64'hDEAD, '0, 2'd3, 1, 0, 0, "R6 maint reply");
      op(3'd5, BASE + 16'd24, 4'd8, 64'hDEAD, '0, 2'd3, 0, 0, 0, "R6 maint silent");
      op(3'd0, BASE + 16'd24, 4'd8, '0, '0, 2'd0, 1, 0, 0, "R6 unchanged");
      // R7 no reply requested
      op(3'd0, BASE, 4'd8, '0, '0, 2'd1, 0, 0, 0, "R7 read no reply");
      op(3'd2, BASE, 4'd4, 64'h55, '0, 2'd1, 0, 0, 0, "R7 swap no reply");
      // R10 instruction fetch
      for (int i = 0; i < 6; i++)
         op(3'd0, BASE + 16'(i*4), 4'(4 + 4*(i%2)) , '0, '0, 2'd2, 1, 1, 0, "R10 ifetch read");
      // R11 saturation
      for (int i = 0; i < 40; i++)
         op(3'd0, BASE + 16'((i%DEPTH)*8), 4'd8, '0, '0, 2'd3, 1, 0, 0, "R11 sat read");
      // R9 / R10 / R11 counters
      for (int s = 0; s < 4; s++) begin
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            stat_src = 2'(s); stat_sel = 3'(k);
            #1;
            chk(stat_value === CNT_W'(k < 6 ? st[s][k] : 0),
                (k == 5) ? "R10 counter" : (k == 3 && s == 3) ? "R11 counter" : "R9 counter",
                64'(stat_value), 64'(k < 6 ? st[s][k] : 0));
         end
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule